// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar date in packed BCD. It divides a 512 Hz enable input down to a one-second tick. Each second it advances seconds, minutes and hours on a 24-hour clock, the day of the week, the date, the month and a two-digit year. The date rolls over at the real length of each month, and February has 29 days whenever the year is a multiple of four.

Software or a surrounding bus block sets the time through a parallel load port, which writes all seven fields in one cycle. A stop input freezes the count. A frequency-test input replaces the seconds LSB on readout with a flop that toggles on every 512 Hz enable, so the divider clock can be measured on one output bit.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the outputs read 00 seconds, 00 minutes, 00 hours, day-of-week 01, date 01, month 01 and year 00. Every field is packed BCD: tens digit in bits 7:4, units digit in bits 3:0. The ranges are seconds and minutes 00-59, hours 00-23, day-of-week 01-07, date 01-31, month 01-12 and year 00-99.
- R2: The seconds field advances by one on the 512th cycle in which `tick512_i` is high, counted since reset or since the last load. Cycles with `tick512_i` low do not count.
- R3: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and advance the date.
- R4: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 28 in February of a non-leap year.
- R5: A year whose value is divisible by four, including 00, is a leap year. In a leap year February runs to day 29.
- R6: Day-of-week advances on every date change and wraps from 07 to 01.
- R7: Month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R8: With `load_i` high, all seven fields take the load inputs at the next clock edge. This takes priority over a tick in the same cycle, and the load also clears the 512-count divider.
- R9: While `stop_i` is 1, neither the divider nor any time field advances, whatever `tick512_i` does.
- R10: A test flop toggles on each cycle where `tick512_i` is 1, `stop_i` is 0 and `ftest_i` is 1. While `ftest_i` is 1, `sec_o[0]` shows that flop in place of the seconds units LSB; the seconds count itself is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick512_i | input | 1 | 512 Hz enable, one cycle wide |
| stop_i | input | 1 | Freeze divider and counters |
| ftest_i | input | 1 | Frequency-test readout on sec_o[0] |
| load_i | input | 1 | Parallel load strobe |
| ld_sec_i | input | 8 | Load value, seconds (BCD) |
| ld_min_i | input | 8 | Load value, minutes (BCD) |
| ld_hour_i | input | 8 | Load value, hours (BCD) |
| ld_dow_i | input | 8 | Load value, day of week (BCD) |
| ld_date_i | input | 8 | Load value, date (BCD) |
| ld_mon_i | input | 8 | Load value, month (BCD) |
| ld_year_i | input | 8 | Load value, year (BCD) |
| sec_o | output | 8 | Seconds (BCD) |
| min_o | output | 8 | Minutes (BCD) |
| hour_o | output | 8 | Hours (BCD) |
| dow_o | output | 8 | Day of week (BCD) |
| date_o | output | 8 | Date (BCD) |
| mon_o | output | 8 | Month (BCD) |
| year_o | output | 8 | Year (BCD) |

## Verification
A parallel load and the 512th divider enable can arrive in the same cycle, and so can a load and a stop. The bench raises `load_i` with `tick512_i` held high, including on a cycle where the divider sits at its last count. The load values must appear unchanged, and the next second must still need a full 512 enables. The same reference model also covers the collision of every rollover stage with one second-tick: the time is loaded to 23:59:59 at month and year ends, so that a single tick ripples through all seven fields.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  typedef logic [7:0] bcd8_t;

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // 10*t + u divisible by 4  <=>  (2*t[0] + u[1:0]) mod 4 == 0
  function automatic logic is_leap(input bcd8_t y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};
    return s == 2'b00;
  endfunction
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int unsigned PRESCALE = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  generate
    if ((1 << PW) == PRESCALE) begin : g_pow2
      assign at_last = &cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_mod
      assign at_last = (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

  assign tick_o = en_i && !clr_i && at_last;
endmodule

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import bcd_cal_pkg::*;
#(
  parameter bcd8_t RST_VAL = 8'h00,
  parameter bcd8_t WRAP_TO = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  inc_i,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  input  bcd8_t last_i,
  output bcd8_t val_o,
  output logic  wrap_o
);
  bcd8_t val_q;
  logic  at_last;

  assign at_last = (val_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= at_last ? WRAP_TO : bcd_inc(val_q);
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i && !load_i && at_last;
endmodule

// File: rtl/month_len.sv
module month_len
  import bcd_cal_pkg::*;
(
  input  bcd8_t mon_i,
  input  bcd8_t year_i,
  output bcd8_t last_date_o
);
  always_comb begin
    unique case (mon_i)
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      8'h02:                      last_date_o = is_leap(year_i) ? 8'h29 : 8'h28;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
#(
  parameter int unsigned PRESCALE = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick512_i,
  input  logic       stop_i,
  input  logic       ftest_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  logic  run_en, sec_tick, test_q;
  logic  sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, dow_wrap, year_wrap;
  bcd8_t sec_q, last_date;

  assign run_en = tick512_i && !stop_i;

  sec_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i, .rst_ni, .en_i(run_en), .clr_i(load_i), .tick_o(sec_tick)
  );

  bcd_wrap_counter #(.RST_VAL(8'h00), .WRAP_TO(8'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(sec_tick), .load_i, .load_val_i(ld_sec_i),
    .last_i(8'h59), .val_o(sec_q), .wrap_o(sec_wrap)
  );
  bcd_wrap_counter #(.RST_VAL(8'h00), .WRAP_TO(8'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .load_i, .load_val_i(ld_min_i),
    .last_i(8'h59), .val_o(min_o), .wrap_o(min_wrap)
  );
  bcd_wrap_counter #(.RST_VAL(8'h00), .WRAP_TO(8'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .load_i, .load_val_i(ld_hour_i),
    .last_i(8'h23), .val_o(hour_o), .wrap_o(hour_wrap)
  );
  bcd_wrap_counter #(.RST_VAL(8'h01), .WRAP_TO(8'h01)) u_dow (
    .clk_i, .rst_ni, .inc_i(hour_wrap), .load_i, .load_val_i(ld_dow_i),
    .last_i(8'h07), .val_o(dow_o), .wrap_o(dow_wrap)
  );

  month_len u_mlen (.mon_i(mon_o), .year_i(year_o), .last_date_o(last_date));

  bcd_wrap_counter #(.RST_VAL(8'h01), .WRAP_TO(8'h01)) u_date (
    .clk_i, .rst_ni, .inc_i(hour_wrap), .load_i, .load_val_i(ld_date_i),
    .last_i(last_date), .val_o(date_o), .wrap_o(date_wrap)
  );
  bcd_wrap_counter #(.RST_VAL(8'h01), .WRAP_TO(8'h01)) u_mon (
    .clk_i, .rst_ni, .inc_i(date_wrap), .load_i, .load_val_i(ld_mon_i),
    .last_i(8'h12), .val_o(mon_o), .wrap_o(mon_wrap)
  );
  bcd_wrap_counter #(.RST_VAL(8'h00), .WRAP_TO(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(mon_wrap), .load_i, .load_val_i(ld_year_i),
    .last_i(8'h99), .val_o(year_o), .wrap_o(year_wrap)
  );

  // divider-rate readout flop for frequency test
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  test_q <= 1'b0;
    else if (run_en && ftest_i)   test_q <= ~test_q;
  end

  assign sec_o = {sec_q[7:1], ftest_i ? test_q : sec_q[0]};
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick512_i,
  input logic       stop_i,
  input logic       ftest_i,
  input logic       load_i,
  input logic [7:0] ld_sec_i,
  input logic [7:0] ld_min_i,
  input logic [7:0] ld_hour_i,
  input logic [7:0] ld_dow_i,
  input logic [7:0] ld_date_i,
  input logic [7:0] ld_mon_i,
  input logic [7:0] ld_year_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o
);
  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ftest_i |-> sec_o <= 8'h59); // R1
  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dow_o >= 8'h01 && dow_o <= 8'h07); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> min_o == $past(ld_min_i) && hour_o == $past(ld_hour_i) &&
               date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
               year_o == $past(ld_year_i) && dow_o == $past(ld_dow_i)); // R8
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable(min_o) && $stable(hour_o) && $stable(date_o) &&
                           $stable(mon_o) && $stable(year_o) && $stable(sec_o[7:1])); // R9
  AST_YEAR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mon_o == 8'h12) |=> (mon_o == 8'h12 || year_o != $past(year_o))); // R7
endmodule

bind bcd_calendar_core bcd_calendar_chk chk_i (.*);

// File: tb/bcd_calendar_core_tb_top.sv
module bcd_calendar_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, stop = 0, ftest = 0, load = 0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_dow = 0, l_date = 0, l_mon = 0, l_year = 0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick512_i(tick), .stop_i(stop), .ftest_i(ftest),
    .load_i(load), .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour),
    .ld_dow_i(l_dow), .ld_date_i(l_date), .ld_mon_i(l_mon), .ld_year_i(l_year),
    .sec_o, .min_o, .hour_o, .dow_o, .date_o, .mon_o, .year_o
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  // behavioural reference model
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_div;
  bit m_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
      m_div = 0; m_t = 0;
    end else begin
      if (tick && !stop && ftest) m_t = !m_t;
      if (load) begin
        m_sec = from_bcd(l_sec); m_min = from_bcd(l_min); m_hr = from_bcd(l_hour);
        m_dow = from_bcd(l_dow); m_date = from_bcd(l_date); m_mon = from_bcd(l_mon);
        m_yr = from_bcd(l_year); m_div = 0;
      end else if (tick && !stop) begin
        m_div++;
        if (m_div == 512) begin
          m_div = 0;
          m_sec++;
          if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
              m_min = 0; m_hr++;
              if (m_hr == 24) begin
                m_hr = 0;
                m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                m_date++;
                if (m_date > days_in(m_mon, m_yr)) begin
                  m_date = 1; m_mon++;
                  if (m_mon == 13) begin
                    m_mon = 1;
                    m_yr = (m_yr + 1) % 100;
                  end
                end
              end
            end
          end
        end
      end
    end
  end

  task automatic cmp(input string f, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur_req, f, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    logic [7:0] es;
    es = to_bcd(m_sec);
    if (ftest) es[0] = m_t;
    vectors++;
    cmp("sec", sec_o, es);
    cmp("min", min_o, to_bcd(m_min));
    cmp("hour", hour_o, to_bcd(m_hr));
    cmp("dow", dow_o, to_bcd(m_dow));
    cmp("date", date_o, to_bcd(m_date));
    cmp("mon", mon_o, to_bcd(m_mon));
    cmp("year", year_o, to_bcd(m_yr));
  endtask

  // one cycle: compare at negedge, then drive next inputs
  task automatic step(input logic t, input logic s, input logic ld);
    @(negedge clk);
    compare_all();
    tick = t; stop = s; load = ld;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) step((gap == 0) || (i % (gap + 1) == 0), stop, 1'b0);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int w,
                          input int h, input int mi, input int s);
    l_year = to_bcd(y); l_mon = to_bcd(mo); l_date = to_bcd(d); l_dow = to_bcd(w);
    l_hour = to_bcd(h); l_min = to_bcd(mi); l_sec = to_bcd(s);
    step(1'b1, stop, 1'b1);   // load with simultaneous tick: load wins (R8)
  endtask

  task automatic roll(input int y, input int mo, input int d, input int w, string rq);
    cur_req = rq;
    set_time(y, mo, d, w, 23, 59, 59);
    run(520, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    @(negedge clk); compare_all();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);

    cur_req = "R2"; run(1100, 0); run(1600, 2);
    cur_req = "R3"; set_time(10, 6, 15, 3, 0, 58, 30); run(16000, 0);
    roll(21, 6, 15, 2, "R3");
    roll(21, 4, 30, 5, "R4");
    roll(21, 1, 31, 1, "R4");
    roll(21, 1, 30, 1, "R4");
    roll(23, 2, 28, 4, "R4");
    roll(24, 2, 28, 4, "R5");
    roll(24, 2, 29, 5, "R5");
    roll(0, 2, 28, 6, "R5");
    roll(22, 9, 30, 7, "R6");
    roll(99, 12, 31, 7, "R7");
    roll(50, 12, 31, 3, "R7");

    cur_req = "R8";
    set_time(5, 5, 5, 5, 5, 5, 5);
    run(511, 0);                         // divider now at last count
    set_time(7, 8, 9, 2, 11, 22, 33);    // load on what would be the second tick
    run(520, 0);
    run(300, 0); set_time(7, 8, 9, 2, 11, 22, 40); run(520, 0);

    cur_req = "R9";
    stop = 1'b1; run(1200, 0);
    set_time(1, 1, 1, 1, 1, 1, 1); run(600, 0);
    stop = 1'b0; run(600, 0);

    cur_req = "R10";
    ftest = 1'b1; run(1100, 0); run(200, 1);
    stop = 1'b1; run(50, 0); stop = 1'b0;
    ftest = 1'b0; run(20, 0);

    @(negedge clk); compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog %s actual=running expected=done", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule